// File: doc/BRIEF.md
# Flow-controlled SD card clock gater

This block decides, for every period of the divided source clock, whether a pulse is passed on to the SD card. In high-speed single-data-rate modes the system bus can fall behind the host FIFOs. When that happens the block withholds card clock pulses, which stalls the card. A read is stalled while the receive FIFO has reached a programmable almost-full level. A write is stalled while the transmit FIFO has no word ready to send. The transfer resumes on the first period after the condition clears, so no data is lost or repeated.

During the tuning command the FIFO state is ignored and a fixed pattern is applied instead: three pulses pass and the fourth is withheld, repeating. The read-sample delay is therefore calibrated under the same gapped clocking that flow control can produce. Outside transfers and tuning the clock runs without gaps.

The enable is captured on the falling edge of the source clock, so an external AND with the source clock yields only whole pulses. An edge strobe, valid at each rising edge, tells the data shifters whether a card edge happens there. A saturating count of withheld pulses is kept for monitoring and is zeroed by a clear pulse.

Top module: `sd_clk_gate`

## Requirements
- R1: Just after reset, clk_en and edge_stb are 1 and gate_count is 0.
- R2: With xfer_active=1 and rd_dir=1 (read), the pulse at a rising edge is withheld (clk_en=0) when rx_level >= rx_thresh held during the preceding period. It passes when rx_level < rx_thresh. tx_level has no effect in a read.
- R3: With xfer_active=1 and rd_dir=0 (write), the pulse is withheld when tx_level = 0 during the preceding period and passes when tx_level > 0. rx_level has no effect in a write.
- R4: clk_en changes only while clk is low. A withheld pulse is a whole period, and clk_en is the same just before and just after each rising edge.
- R5: While tuning=1, the FIFO levels and xfer_active are ignored. A 2-bit position counter starts at 0 on the first period with tuning high and advances once per period, wrapping. The pulse that ends a period at position 3 is withheld. The resulting pattern is pass, pass, pass, withhold, repeating, and it restarts whenever tuning is raised again.
- R6: With tuning=0 and xfer_active=0, every pulse passes whatever the FIFO levels.
- R7: edge_stb is 1 exactly at the rising edges where a card pulse is passed.
- R8: gate_count increases by one at each withheld pulse and saturates at 2^CW-1.
- R9: cnt_clear=1 at a rising edge sets gate_count to 0 and takes priority over an increment at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided source clock, one card clock period per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LW | Receive FIFO fill level in words |
| rx_thresh | input | LW | Almost-full level that stalls reads |
| tx_level | input | LW | Transmit FIFO fill level in words |
| rd_dir | input | 1 | 1 = read transfer, 0 = write transfer |
| xfer_active | input | 1 | Data transfer in progress |
| tuning | input | 1 | Tuning command in progress |
| cnt_clear | input | 1 | Zero the withheld-pulse counter |
| clk_en | output | 1 | Card clock enable, changes only while clk is low |
| edge_stb | output | 1 | Card edge occurs at the coming rising edge |
| gate_count | output | CW | Saturating count of withheld pulses |

## Verification
Inputs applied during a period decide the pulse at the next rising edge, one edge later. clk_en and edge_stb are set at the falling edge in between, and gate_count moves at that rising edge. The bench changes inputs 1 ns after a rising edge and predicts each edge from its own model of the rules. It checks clk_en, edge_stb and gate_count 1 ns after the following rising edge, so every result is read in the period it is due. It also samples clk_en late in the low phase and requires the same value after the edge, which shows that the enable never moves while the clock is high.

// File: rtl/sd_clk_gate.sv
module sd_clk_gate #(
  parameter int LW = 5,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] rx_thresh,
  input  logic [LW-1:0] tx_level,
  input  logic          rd_dir,
  input  logic          xfer_active,
  input  logic          tuning,
  input  logic          cnt_clear,
  output logic          clk_en,
  output logic          edge_stb,
  output logic [CW-1:0] gate_count
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [1:0]    tune_pos;
  logic          en_q;
  logic [CW-1:0] gcnt;

  wire rx_stall = rd_dir  && (rx_level >= rx_thresh);
  wire tx_stall = !rd_dir && (tx_level == '0);
  wire pass     = tuning ? (tune_pos != 2'd3)
                         : !(xfer_active && (rx_stall || tx_stall));

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= pass;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      tune_pos <= 2'd0;
    else if (tuning) tune_pos <= tune_pos + 2'd1;
    else             tune_pos <= 2'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      gcnt <= '0;
    else if (cnt_clear)              gcnt <= '0;
    else if (!en_q && gcnt != CNT_MAX) gcnt <= gcnt + 1'b1;

  assign clk_en     = en_q;
  assign edge_stb   = en_q;
  assign gate_count = gcnt;
endmodule

module sd_clk_gate_chk #(
  parameter int LW = 5,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] rx_thresh,
  input logic [LW-1:0] tx_level,
  input logic          rd_dir,
  input logic          xfer_active,
  input logic          tuning,
  input logic          cnt_clear,
  input logic          clk_en,
  input logic          edge_stb,
  input logic [CW-1:0] gate_count
);
  // R2
  rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tuning && xfer_active && rd_dir && rx_level >= rx_thresh) |-> !clk_en);

  // R3
  wr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tuning && xfer_active && !rd_dir && tx_level == '0) |-> !clk_en);

  // R6
  idle_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tuning && !xfer_active) |-> clk_en);

  // R5
  tune_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tuning && !clk_en) |=> (tuning -> clk_en));

  // R7
  strobe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb == clk_en);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clear && !clk_en && gate_count != {CW{1'b1}}) |=> gate_count == $past(gate_count) + 1'b1);

  // R9
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> gate_count == '0);

  // R4
  always @(clk_en)
    if (rst_n) glitch_free_chk: assert (!clk);
endmodule

bind sd_clk_gate sd_clk_gate_chk #(.LW(LW), .CW(CW)) u_chk (.*);

// File: tb/sd_clk_gate_bench.sv
module sd_clk_gate_bench;
  localparam int LW = 5;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] rx_level = '0, rx_thresh = 5'd12, tx_level = '0;
  logic          rd_dir = 1'b0, xfer_active = 1'b0, tuning = 1'b0, cnt_clear = 1'b0;
  logic          clk_en, edge_stb;
  logic [CW-1:0] gate_count;

  int nchk = 0, nfail = 0;
  int m_cnt = 0;
  int m_pos = 0;

  always #4 clk = ~clk;

  sd_clk_gate #(.LW(LW), .CW(CW)) u_sd_clk_gate (.*);

  task automatic check(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_pass();
    if (tuning) return m_pos != 3;
    if (xfer_active && (rd_dir ? (rx_level >= rx_thresh) : (tx_level == 0))) return 1'b0;
    return 1'b1;
  endfunction

  // entered 1 ns after a rising edge; checks the pulse at the next edge
  task automatic cyc(input string tag);
    bit e;
    bit pre;
    e = exp_pass();
    #6;
    pre = clk_en;
    @(posedge clk);
    #1;
    if (cnt_clear) m_cnt = 0;
    else if (!e && m_cnt < (1 << CW) - 1) m_cnt++;
    m_pos = tuning ? (m_pos + 1) % 4 : 0;
    check(tag, "clk_en", clk_en, e);
    check("R7", "edge_stb", edge_stb, e);
    check("R4", "clk_en across edge", clk_en, pre);
    check("R8", "gate_count", gate_count, m_cnt);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #20;
    check("R1", "clk_en", clk_en, 1);
    check("R1", "edge_stb", edge_stb, 1);
    check("R1", "gate_count", gate_count, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    m_cnt = 0;
    m_pos = 0;
  endtask

  task automatic t_idle();
    xfer_active = 1'b0;
    rd_dir = 1'b1;
    rx_level = 5'd16;
    tx_level = '0;
    for (int i = 0; i < 4; i++) cyc("R6");
    rd_dir = 1'b0;
    for (int i = 0; i < 4; i++) cyc("R6");
  endtask

  task automatic t_read();
    xfer_active = 1'b1;
    rd_dir = 1'b1;
    tx_level = '0;
    rx_thresh = 5'd12;
    rx_level = 5'd11; cyc("R2");
    rx_level = 5'd12; for (int i = 0; i < 3; i++) cyc("R2");
    rx_level = 5'd16; cyc("R2");
    rx_level = 5'd5;  cyc("R2"); cyc("R2");
    rx_thresh = 5'd16;
    rx_level = 5'd15; cyc("R2");
    rx_level = 5'd16; cyc("R2");
    rx_level = 5'd0;  cyc("R2");
  endtask

  task automatic t_write();
    xfer_active = 1'b1;
    rd_dir = 1'b0;
    rx_level = 5'd16;
    rx_thresh = 5'd4;
    tx_level = 5'd3; cyc("R3");
    tx_level = 5'd0; for (int i = 0; i < 3; i++) cyc("R3");
    tx_level = 5'd1; cyc("R3");
    tx_level = 5'd0; cyc("R3");
    tx_level = 5'd16; cyc("R3");
  endtask

  task automatic t_tune();
    xfer_active = 1'b1;
    rd_dir = 1'b1;
    rx_level = 5'd16;
    rx_thresh = 5'd2;
    tuning = 1'b1;
    for (int i = 0; i < 10; i++) cyc("R5");
    tuning = 1'b0;
    xfer_active = 1'b0;
    cyc("R5");
    tuning = 1'b1;
    rd_dir = 1'b0;
    tx_level = 5'd4;
    xfer_active = 1'b1;
    for (int i = 0; i < 5; i++) cyc("R5");
    tuning = 1'b0;
    xfer_active = 1'b0;
    cyc("R5");
  endtask

  task automatic t_count();
    xfer_active = 1'b1;
    rd_dir = 1'b0;
    tx_level = '0;
    tuning = 1'b0;
    for (int i = 0; i < 270; i++) cyc("R8");
    check("R8", "saturated gate_count", gate_count, (1 << CW) - 1);
  endtask

  task automatic t_clear();
    cnt_clear = 1'b1;
    cyc("R9");
    check("R9", "gate_count after clear while stalled", gate_count, 0);
    cnt_clear = 1'b0;
    cyc("R9");
    cyc("R9");
    check("R9", "gate_count counts again", gate_count, 2);
    xfer_active = 1'b0;
    cyc("R9");
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_read();
    t_write();
    t_tune();
    t_count();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule